// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block gathers sixteen external request lines, one non-maskable line and seven internal exception sources. It qualifies each one and offers the CPU one winning request on a valid/ready pair, together with the request's vector number and its effective priority. Each external line passes through a two-stage synchronizer. It then has its own sense mode (low level, falling edge, rising edge or both edges), an enable bit and a 3-bit priority. The non-maskable line and the internal exceptions sit at a fixed level 8, above every programmable level, and are accepted whatever the CPU's mask state.

The block has two acceptance modes. In flat mode a maskable request is accepted only while the CPU's single global mask bit is clear. In level mode a maskable request is accepted only if its priority is strictly above the CPU's 3-bit current level. Among the accepted requests the highest effective priority wins, and a tie goes to the lowest vector number.

The CPU takes a request by raising `int_ready_i` while `int_valid_o` is high. That cycle is the handshake. It clears the edge-pending flag of the presented source. On the next cycle the block pulses `lvl_load_o` with the level the CPU should raise its mask to. Back-pressure rule: while `int_ready_i` is low, no pending request is lost. The offered vector is not frozen, though: a higher request that arrives takes its place, and a level-sensed request that goes away withdraws `int_valid_o`. This is deliberate for an interrupt path.

Top module: `prio_intc`

## Requirements
- R1: After reset `int_valid_o` and `lvl_load_o` are 0, and every register address reads back 0.
- R2: Register map, written while `reg_we_i` is high and read combinationally on `reg_rdata_o`. Address 0: bits[1:0] mode, bit2 non-maskable edge select. Address 1: enable bit n for line n. Address 2: line j (0..7) sense in bits[2j+1:2j]. Address 3: line 8+j sense in bits[2j+1:2j]. Address 4+g: line 4g+j priority in bits[4j+2:4j]. Bits that are not defined read 0.
- R3: Mode values 0 (flat) and 2 (level) are stored. A write carrying mode 1 or 3 leaves the stored mode unchanged.
- R4: Sense codes are 00 low level, 01 falling edge, 10 rising edge and 11 both edges. A line change made after clock edge k is presented after edge k+3 for an edge sense and after edge k+2 for a level sense.
- R5: An edge request stays pending until its own handshake. A level request follows the synchronized input, and a handshake has no effect on it.
- R6: A line whose enable bit is 0 is never presented.
- R7: In flat mode a maskable request is presented only while `cpu_mask_i` is 0.
- R8: In level mode a maskable request is presented only when its priority is strictly greater than `cpu_level_i`.
- R9: The presented request has the highest effective priority among the accepted ones, and a tie goes to the lowest vector.
- R10: The non-maskable source uses vector 0. Exceptions `exc_i[k]` use vector k+1 and latch for one cycle's pulse. All of them have effective priority 8, are accepted in every mode and under any mask, and the non-maskable source outranks all others.
- R11: When edge select is 0 the non-maskable line triggers on a falling edge. When it is 1 the line triggers on a rising edge.
- R12: External line n uses vector `IRQ_VEC_BASE`+n, with a default base of 64.
- R13: After a handshake `lvl_load_o` is 1 for exactly one cycle, and `lvl_o` holds the accepted priority, clamped to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| irq_i | input | 16 | External request lines (idle high) |
| nmi_i | input | 1 | Non-maskable request line |
| exc_i | input | 7 | Internal exception pulses |
| cpu_mask_i | input | 1 | CPU global mask bit (flat mode) |
| cpu_level_i | input | 3 | CPU current priority level (level mode) |
| int_valid_o | output | 1 | A request is offered |
| int_ready_i | input | 1 | CPU accepts the offered request |
| int_vec_o | output | 8 | Vector of the offered request |
| int_prio_o | output | 4 | Effective priority of the offered request (8 = fixed) |
| lvl_load_o | output | 1 | One-cycle pulse after a handshake |
| lvl_o | output | 3 | Level to load into the CPU mask |

## Verification
A pending flag left stale after its handshake shows up on the very next cycle: `int_valid_o` stays high with the same vector. A flag that was never set keeps `int_valid_o` low three cycles after the line edge. Decoding the sense code or the edge select wrongly shows at the ports within three cycles of the line change, either as a missing request or as an unexpected one. An error in the selection order shows at the next handshake, where the scoreboard sees a vector or priority that differs from the expected sequence.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int N_IRQ   = 16;
  localparam int N_EXC   = 7;
  localparam int N_FIX   = N_EXC + 1;
  localparam int N_SRC   = N_FIX + N_IRQ;
  localparam int PRIO_W  = 3;
  localparam int EPRIO_W = PRIO_W + 1;
  localparam int VEC_W   = 8;
  localparam int IDX_W   = $clog2(N_SRC);
  localparam logic [EPRIO_W-1:0] PRIO_FIXED = EPRIO_W'(8);

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_FALL = 2'b01,
    SENSE_RISE = 2'b10,
    SENSE_BOTH = 2'b11
  } sense_e;

  typedef enum logic [1:0] {
    MODE_FLAT  = 2'b00,
    MODE_LEVEL = 2'b10
  } imode_e;
endpackage

// File: rtl/intc_line.sv
module intc_line
  import intc_pkg::*;
#(
  parameter int   STAGES    = 2,
  parameter logic IDLE_VAL  = 1'b1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   raw_i,
  input  sense_e sense_i,
  input  logic   clr_i,
  output logic   req_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              pend_q;
  logic              cur;
  logic              hit;

  assign cur = sync_q[STAGES-1];

  always_comb begin
    unique case (sense_i)
      SENSE_FALL: hit = prev_q & ~cur;
      SENSE_RISE: hit = ~prev_q & cur;
      SENSE_BOTH: hit = prev_q ^ cur;
      default:    hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {STAGES{IDLE_VAL}};
      prev_q <= IDLE_VAL;
      pend_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], raw_i};
      prev_q <= cur;
      if (sense_i == SENSE_LOW) pend_q <= 1'b0;
      else                      pend_q <= (pend_q & ~clr_i) | hit;
    end
  end

  assign req_o = (sense_i == SENSE_LOW) ? ~cur : pend_q;

  // R5: an edge request stays pending until its own clear
  p_pend_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr_i && sense_i != SENSE_LOW) |=> pend_q);
endmodule

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we_i,
  input  logic [2:0]                   addr_i,
  input  logic [15:0]                  wdata_i,
  output logic [15:0]                  rdata_o,
  output imode_e                       mode_o,
  output logic                         nmi_rise_o,
  output logic [N_IRQ-1:0]             en_o,
  output logic [N_IRQ-1:0][1:0]        sense_o,
  output logic [N_IRQ-1:0][PRIO_W-1:0] prio_o
);
  localparam int PER_PRIO_REG  = 4;
  localparam int PER_SENSE_REG = 8;

  imode_e                       mode_q;
  logic                         nmi_rise_q;
  logic [N_IRQ-1:0]             en_q;
  logic [N_IRQ-1:0][1:0]        sense_q;
  logic [N_IRQ-1:0][PRIO_W-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q     <= MODE_FLAT;
      nmi_rise_q <= 1'b0;
      en_q       <= '0;
      sense_q    <= '0;
      prio_q     <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        3'd0: begin
          if (wdata_i[0] == 1'b0) mode_q <= imode_e'(wdata_i[1:0]);
          nmi_rise_q <= wdata_i[2];
        end
        3'd1: en_q <= wdata_i[N_IRQ-1:0];
        3'd2, 3'd3: begin
          for (int j = 0; j < PER_SENSE_REG; j++)
            sense_q[{addr_i[0], 3'(j)}] <= wdata_i[2*j +: 2];
        end
        default: begin
          for (int j = 0; j < PER_PRIO_REG; j++)
            prio_q[{addr_i[1:0], 2'(j)}] <= wdata_i[4*j +: PRIO_W];
        end
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      3'd0: rdata_o[2:0] = {nmi_rise_q, mode_q};
      3'd1: rdata_o = en_q;
      3'd2, 3'd3: begin
        for (int j = 0; j < PER_SENSE_REG; j++)
          rdata_o[2*j +: 2] = sense_q[{addr_i[0], 3'(j)}];
      end
      default: begin
        for (int j = 0; j < PER_PRIO_REG; j++)
          rdata_o[4*j +: PRIO_W] = prio_q[{addr_i[1:0], 2'(j)}];
      end
    endcase
  end

  assign mode_o     = mode_q;
  assign nmi_rise_o = nmi_rise_q;
  assign en_o       = en_q;
  assign sense_o    = sense_q;
  assign prio_o     = prio_q;

  // R3: only the two legal mode codes are ever stored
  p_mode_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_FLAT) || (mode_q == MODE_LEVEL));
endmodule

// File: rtl/intc_select.sv
module intc_select #(
  parameter int NSRC = 24,
  parameter int PW   = 4,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]         cand_i,
  input  logic [NSRC-1:0][PW-1:0] prio_i,
  output logic                    any_o,
  output logic [IW-1:0]           idx_o,
  output logic [PW-1:0]           prio_o
);
  // scan from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    any_o  = 1'b0;
    idx_o  = '0;
    prio_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand_i[i] && (!any_o || prio_i[i] >= prio_o)) begin
        any_o  = 1'b1;
        idx_o  = IW'(i);
        prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int IRQ_VEC_BASE = 64,
  parameter int SYNC_STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [15:0]        reg_wdata_i,
  output logic [15:0]        reg_rdata_o,
  input  logic [N_IRQ-1:0]   irq_i,
  input  logic               nmi_i,
  input  logic [N_EXC-1:0]   exc_i,
  input  logic               cpu_mask_i,
  input  logic [PRIO_W-1:0]  cpu_level_i,
  output logic               int_valid_o,
  input  logic               int_ready_i,
  output logic [VEC_W-1:0]   int_vec_o,
  output logic [EPRIO_W-1:0] int_prio_o,
  output logic               lvl_load_o,
  output logic [PRIO_W-1:0]  lvl_o
);
  imode_e                       mode;
  logic                         nmi_rise;
  logic [N_IRQ-1:0]             irq_en;
  logic [N_IRQ-1:0][1:0]        irq_sense;
  logic [N_IRQ-1:0][PRIO_W-1:0] irq_prio;

  logic [N_IRQ-1:0]              irq_req;
  logic                          nmi_req;
  logic [N_EXC-1:0]              exc_pend_q;
  logic [N_SRC-1:0]              cand;
  logic [N_SRC-1:0][EPRIO_W-1:0] eprio;
  logic [N_SRC-1:0]              clr;
  logic [IDX_W-1:0]              win_idx;
  logic                          fire;
  logic                          lvl_load_q;
  logic [PRIO_W-1:0]             lvl_q;

  intc_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .mode_o     (mode),
    .nmi_rise_o (nmi_rise),
    .en_o       (irq_en),
    .sense_o    (irq_sense),
    .prio_o     (irq_prio)
  );

  intc_line #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_i   (nmi_i),
    .sense_i (nmi_rise ? SENSE_RISE : SENSE_FALL),
    .clr_i   (clr[0]),
    .req_o   (nmi_req)
  );

  for (genvar n = 0; n < N_IRQ; n++) begin : g_line
    intc_line #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (irq_i[n]),
      .sense_i (sense_e'(irq_sense[n])),
      .clr_i   (clr[N_FIX+n]),
      .req_o   (irq_req[n])
    );
    assign cand[N_FIX+n]  = irq_req[n] & irq_en[n] &
                            ((mode == MODE_FLAT) ? ~cpu_mask_i
                                                 : (irq_prio[n] > cpu_level_i));
    assign eprio[N_FIX+n] = {1'b0, irq_prio[n]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) exc_pend_q <= '0;
    else        exc_pend_q <= (exc_pend_q & ~clr[N_FIX-1:1]) | exc_i;
  end

  assign cand[0]  = nmi_req;
  assign eprio[0] = PRIO_FIXED;
  for (genvar k = 0; k < N_EXC; k++) begin : g_exc
    assign cand[1+k]  = exc_pend_q[k];
    assign eprio[1+k] = PRIO_FIXED;
  end

  intc_select #(.NSRC(N_SRC), .PW(EPRIO_W)) u_sel (
    .cand_i (cand),
    .prio_i (eprio),
    .any_o  (int_valid_o),
    .idx_o  (win_idx),
    .prio_o (int_prio_o)
  );

  assign int_vec_o = (int'(win_idx) < N_FIX) ? VEC_W'(win_idx)
                                             : VEC_W'(IRQ_VEC_BASE + int'(win_idx) - N_FIX);
  assign fire = int_valid_o & int_ready_i;

  always_comb begin
    clr = '0;
    if (fire) clr[win_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_load_q <= 1'b0;
      lvl_q      <= '0;
    end else begin
      lvl_load_q <= fire;
      if (fire) lvl_q <= int_prio_o[EPRIO_W-1] ? {PRIO_W{1'b1}} : int_prio_o[PRIO_W-1:0];
    end
  end

  assign lvl_load_o = lvl_load_q;
  assign lvl_o      = lvl_q;

  // R10: the non-maskable source always wins
  p_nmi_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req |-> (int_valid_o && int_vec_o == '0));
  // R10: fixed vectors carry priority 8
  p_fixed_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid_o && int_vec_o < VEC_W'(N_FIX)) |-> (int_prio_o == PRIO_FIXED));
  // R8: level mode gate
  p_mode2_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid_o && mode == MODE_LEVEL && int_prio_o < PRIO_FIXED)
      |-> (int_prio_o > {1'b0, cpu_level_i}));
  // R7: flat mode gate
  p_mode0_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int_valid_o && mode == MODE_FLAT && int_prio_o < PRIO_FIXED) |-> !cpu_mask_i);
  // R13: level load follows each handshake
  p_level_load_r13: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (lvl_load_o &&
              lvl_o == (($past(int_prio_o) > EPRIO_W'(7)) ? PRIO_W'(7)
                                                         : $past(int_prio_o[PRIO_W-1:0]))));
  // R5: a handshake clears at most one source
  p_single_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr));
endmodule

// File: tb/tb_prio_intc.sv
module tb_prio_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [15:0] irq = 16'hFFFF;
  logic        nmi = 1'b1;
  logic [6:0]  exc = '0;
  logic        cpu_mask = 1'b0;
  logic [2:0]  cpu_level = '0;
  logic        valid;
  logic        rdy = 1'b0;
  logic [7:0]  vec;
  logic [3:0]  prio;
  logic        lvl_load;
  logic [2:0]  lvl;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct { int vec; int prio; } exp_t;
  exp_t sb[$];

  always #4 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rst_n(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_i(irq), .nmi_i(nmi),
    .exc_i(exc), .cpu_mask_i(cpu_mask), .cpu_level_i(cpu_level),
    .int_valid_o(valid), .int_ready_i(rdy), .int_vec_o(vec), .int_prio_o(prio),
    .lvl_load_o(lvl_load), .lvl_o(lvl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string req);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    chk(reg_rdata == exp, req, reg_rdata, exp);
  endtask

  task automatic see(input bit v, input int ev, input int ep, input string req);
    @(negedge clk);
    chk(valid == v, req, valid, v);
    if (v) begin
      chk(vec == ev, req, vec, ev);
      chk(prio == ep, req, prio, ep);
    end
  endtask

  // driver: push the expected item, then hand-shake once
  task automatic ack(input int ev, input int ep);
    exp_t e;
    e.vec = ev; e.prio = ep;
    sb.push_back(e);
    @(posedge clk); #1 rdy = 1'b1;
    @(posedge clk); #1 rdy = 1'b0;
    @(negedge clk);
    chk(lvl_load == 1'b1, "R13 load", lvl_load, 1);
    chk(lvl == ((ep > 7) ? 7 : ep), "R13 level", lvl, (ep > 7) ? 7 : ep);
  endtask

  // monitor: compare every handshake against the scoreboard
  always @(negedge clk) begin
    if (rst_n && valid && rdy) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 unexpected handshake", vec, -1);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(vec == e.vec, "R9/R12 vector", vec, e.vec);
        chk(prio == e.prio, "R9 priority", prio, e.prio);
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_up();
  end

  initial begin
    cyc(5);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(valid == 1'b0, "R1 valid", valid, 0);
    chk(lvl_load == 1'b0, "R1 load", lvl_load, 0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 16'h0000, "R1 readback");

    // R2 map and unused bits
    wr(3'd1, 16'hFFFF);
    rd_chk(3'd1, 16'hFFFF, "R2 enable");
    wr(3'd4, 16'hFFFF);
    rd_chk(3'd4, 16'h7777, "R2 prio bits");

    // R3 mode codes
    wr(3'd0, 16'h0002);
    rd_chk(3'd0, 16'h0002, "R3 mode 2");
    wr(3'd0, 16'h0001);
    rd_chk(3'd0, 16'h0002, "R3 mode 1 ignored");

    wr(3'd4, 16'h5030);
    wr(3'd5, 16'h3040);
    wr(3'd6, 16'h2640);
    wr(3'd7, 16'h0507);
    wr(3'd2, 16'h0844);
    wr(3'd3, 16'h2398);
    wr(3'd1, 16'hBFFF);
    rd_chk(3'd3, 16'h2398, "R2 sense");
    cpu_level = 3'd2;

    // R4 falling edge timing, R5 hold, R12 vector, R13
    @(posedge clk); #1 irq[3] = 1'b0;
    @(posedge clk); @(posedge clk);
    see(1'b0, 0, 0, "R4 not before edge 3");
    @(posedge clk);
    see(1'b1, 67, 5, "R4/R12 edge 3");
    #1 irq[3] = 1'b1;
    cyc(6);
    see(1'b1, 67, 5, "R5 pending held");
    ack(67, 5);
    chk(valid == 1'b0, "R5 cleared", valid, 0);

    // R9 tie: lowest vector first
    @(posedge clk); #1 irq[5] = 1'b0; irq[9] = 1'b0;
    cyc(4);
    irq[5] = 1'b1; irq[9] = 1'b1;
    cyc(4);
    see(1'b1, 69, 4, "R9 tie");
    ack(69, 4);
    ack(73, 4);
    chk(valid == 1'b0, "R9 drained", valid, 0);

    // R9 higher priority wins
    @(posedge clk); #1 irq[1] = 1'b0; irq[10] = 1'b0;
    cyc(4);
    see(1'b1, 74, 6, "R9 higher wins");
    ack(74, 6);
    ack(65, 3);
    irq[1] = 1'b1; irq[10] = 1'b1;

    // R8 level gate
    @(posedge clk); #1 irq[11] = 1'b0;
    cyc(4);
    irq[11] = 1'b1;
    cyc(4);
    see(1'b0, 0, 0, "R8 equal level blocked");
    cpu_level = 3'd1;
    see(1'b1, 75, 2, "R8 above level");
    ack(75, 2);
    cpu_level = 3'd2;

    // R5 level sense follows input
    @(posedge clk); #1 irq[7] = 1'b0;
    @(posedge clk); @(posedge clk);
    see(1'b1, 71, 3, "R4 level after edge 2");
    cyc(4);
    ack(71, 3);
    chk(valid == 1'b1 && vec == 71, "R5 level unaffected by ack", vec, 71);
    @(posedge clk); #1 irq[7] = 1'b1;
    cyc(3);
    see(1'b0, 0, 0, "R5 level withdrawn");

    // R4 both edges
    @(posedge clk); #1 irq[12] = 1'b0;
    cyc(4);
    see(1'b1, 76, 7, "R4 both falling");
    ack(76, 7);
    chk(valid == 1'b0, "R4 both cleared", valid, 0);
    @(posedge clk); #1 irq[12] = 1'b1;
    cyc(4);
    see(1'b1, 76, 7, "R4 both rising");
    ack(76, 7);

    // R6 disabled line
    @(posedge clk); #1 irq[14] = 1'b0;
    cyc(4);
    irq[14] = 1'b1;
    cyc(4);
    see(1'b0, 0, 0, "R6 disabled");

    // R7 flat mode, R10 exception under mask
    wr(3'd0, 16'h0000);
    cpu_mask = 1'b1;
    @(posedge clk); #1 irq[3] = 1'b0;
    cyc(4);
    see(1'b0, 0, 0, "R7 masked");
    @(posedge clk); #1 exc[2] = 1'b1;
    @(posedge clk); #1 exc[2] = 1'b0;
    see(1'b1, 3, 8, "R10 exception under mask");
    ack(3, 8);
    chk(valid == 1'b0, "R7 still masked", valid, 0);
    @(posedge clk); #1 cpu_mask = 1'b0;
    see(1'b1, 67, 5, "R7 unmasked");
    ack(67, 5);
    irq[3] = 1'b1;

    // R10 NMI outranks exception; R11 edge select
    cpu_mask = 1'b1;
    @(posedge clk); #1 nmi = 1'b0;
    cyc(4);
    exc[0] = 1'b1;
    @(posedge clk); #1 exc[0] = 1'b0;
    see(1'b1, 0, 8, "R10 nmi first");
    ack(0, 8);
    ack(1, 8);
    @(posedge clk); #1 nmi = 1'b1;
    cyc(4);
    see(1'b0, 0, 0, "R11 rise ignored in falling mode");
    wr(3'd0, 16'h0004);
    rd_chk(3'd0, 16'h0004, "R2 edge select bit");
    @(posedge clk); #1 nmi = 1'b0;
    cyc(4);
    see(1'b0, 0, 0, "R11 fall ignored in rising mode");
    nmi = 1'b1;
    cyc(4);
    see(1'b1, 0, 8, "R11 rising");
    ack(0, 8);

    cyc(3);
    chk(sb.size() == 0, "R9 scoreboard empty", sb.size(), 0);
    finish_up();
  end
endmodule